// File: doc/BRIEF.md
# Flash Byte Programming Controller

This block sits between a parallel programming port and a register-held model of an on-chip nonvolatile code store. Each cycle the host presents an address, a data byte, a three-bit mode code and an active-low program strobe. From these the block runs self-timed byte writes, a whole-array erase, verify reads of stored code, signature reads and programming of two protection bits. Write and erase durations are parameters counted in clock cycles. Simulation can therefore shorten them, and silicon-scale values are used by default.

The host can track a write in two ways. A ready output drops for the length of the write. While the write is in flight, a verify read returns the pending byte with its top bit inverted, so the host can poll until the true value comes back. A location that already holds code is never programmed a second time. Only an erase of the whole array makes it writable again. When both protection bits are set, verify reads no longer return stored code. The protection bits themselves cannot be read.

Top module: `nvm_prog_ctrl`

## Requirements
- R1: After synchronous reset, ready_o is 1 and rdata_o is FFH. Every location is blank and both protection bits are clear.
- R2: A verify read (mode 2) of a location never written since reset or since the last erase returns FFH.
- R3: Each accepted write or protection-bit operation holds ready_o low for exactly WRITE_CYC cycles. The low period starts in the cycle after the edge that detected the strobe rise.
- R4: An operation starts only at an edge where strobe_n_i is sampled 1 and was sampled 0 at the previous edge. The mode sampled at that edge must be 1 (byte write), 5 (protection bit 1) or 6 (protection bit 2).
- R5: Once a byte write completes, a verify read of its address returns the written byte.
- R6: While a byte write is busy and neither protection state applies, a verify read of any address returns the pending byte with bit 7 inverted and bits 6:0 unchanged.
- R7: A signature read (mode 4) returns 1EH at address 30H and 51H at 31H. At 32H it returns FFH when HV_VARIANT is 1 and 05H otherwise. Any other address returns FFH. Busy state and protection do not affect it.
- R8: A read command (mode 2 or 4) sampled at edge t appears on rdata_o after edge t+1. rdata_o changes at no other time.
- R9: A byte write to a location that already holds code is rejected. ready_o stays 1 and the stored byte is kept. After an erase, the same location accepts a write.
- R10: Any strobe rise or erase hold arriving while busy is ignored. The location it targeted still reads FFH afterwards.
- R11: Once both protection bits are programmed, a verify read returns 00H. With only one bit set, verify is unaffected.
- R12: Holding strobe_n_i at 0 with mode 3 for ERASE_CYC consecutive edges blanks every location and clears both protection bits. A shorter hold changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | AW | Location or signature index |
| data_i | input | 8 | Byte to program |
| mode_i | input | 3 | Operation code: 0 idle, 1 write, 2 verify, 3 erase, 4 signature, 5/6 protection bit 1/2 |
| strobe_n_i | input | 1 | Active-low program strobe |
| ready_o | output | 1 | 1 when idle, 0 while a timed operation runs |
| rdata_o | output | 8 | Read-back byte |

## Verification
ready_o falls one cycle after the edge that samples the strobe rise and stays low for WRITE_CYC cycles. A read command sampled at one edge appears on rdata_o two edges later. An erase takes effect at the ERASE_CYC-th low sample. The bench holds a behavioural model that advances on each rising edge from the same sampled inputs. It compares both outputs against that model at every falling edge. Directed checks step through a read one falling edge at a time, so they sample exactly in the cycle where the result is due. Poll checks are issued early enough in the write window to land inside it.

// File: rtl/nvm_prog_pkg.sv
package nvm_prog_pkg;

  typedef enum logic [2:0] {
    CMD_NONE   = 3'd0,
    CMD_WRITE  = 3'd1,
    CMD_VERIFY = 3'd2,
    CMD_ERASE  = 3'd3,
    CMD_SIGN   = 3'd4,
    CMD_LOCK1  = 3'd5,
    CMD_LOCK2  = 3'd6
  } cmd_e;

  typedef enum logic [1:0] {
    RK_ARRAY,
    RK_POLL,
    RK_LOCKED,
    RK_SIGN
  } rkind_e;

  localparam logic [7:0] BLANK_BYTE  = 8'hFF;
  localparam logic [7:0] HIDDEN_BYTE = 8'h00;
  localparam logic [7:0] SIG_MAKER   = 8'h1E;
  localparam logic [7:0] SIG_FAMILY  = 8'h51;
  localparam logic [7:0] SIG_HIGHV   = 8'hFF;
  localparam logic [7:0] SIG_LOWV    = 8'h05;

  function automatic logic [7:0] sig_byte(input logic [15:0] a, input logic hv);
    case (a)
      16'h0030: sig_byte = SIG_MAKER;
      16'h0031: sig_byte = SIG_FAMILY;
      16'h0032: sig_byte = hv ? SIG_HIGHV : SIG_LOWV;
      default:  sig_byte = BLANK_BYTE;
    endcase
  endfunction

endpackage

// File: rtl/nvm_op_timer.sv
// Down-counter for self-timed operations; busy spans exactly CYCLES clocks.
module nvm_op_timer #(
  parameter int unsigned CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;

  assign done = busy && (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == CW'(1)) busy <= 1'b0;
      cnt <= cnt - 1'b1;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= CW'(CYCLES);
    end
  end
endmodule

// File: rtl/nvm_erase_hold.sv
// Counts consecutive qualified low-strobe samples; fires once per hold.
module nvm_erase_hold #(
  parameter int unsigned HOLD = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_req,
  output logic fire
);
  localparam int CW = $clog2(HOLD + 1);

  logic [CW-1:0] cnt;

  assign fire = hold_req && (cnt == CW'(HOLD - 1));

  always_ff @(posedge clk) begin
    if (rst || !hold_req) cnt <= '0;
    else if (cnt != CW'(HOLD)) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/nvm_code_array.sv
// Byte store written as plain RAM, plus a flop map of programmed locations
// so an erase costs one cycle instead of a sweep.
module nvm_code_array #(
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  input  logic [AW-1:0] chk_addr,
  output logic [7:0]    rdata,
  output logic          rvalid,
  output logic          chk_blank
);
  localparam int DEPTH = 1 << AW;

  logic [7:0]       mem [DEPTH];
  logic [DEPTH-1:0] used;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst || clear) used <= '0;
    else if (we) used[waddr] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) rvalid <= 1'b0;
    else     rvalid <= used[raddr];
  end

  assign chk_blank = !used[chk_addr];
endmodule

// File: rtl/nvm_prog_ctrl.sv
module nvm_prog_ctrl
  import nvm_prog_pkg::*;
#(
  parameter int unsigned AW         = 8,
  parameter int unsigned WRITE_CYC  = 150000,
  parameter int unsigned ERASE_CYC  = 1000000,
  parameter bit          HV_VARIANT = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  input  logic [2:0]    mode_i,
  input  logic          strobe_n_i,
  output logic          ready_o,
  output logic [7:0]    rdata_o
);
  logic          strb_q;
  logic          rise;
  logic          busy, done;
  logic          start_wr, start_lk;
  logic          op_lock, op_sel2;
  logic [AW-1:0] pend_addr;
  logic [7:0]    pend_data;
  logic          lb1, lb2;
  logic          erase_fire;
  logic          arr_blank, arr_valid;
  logic [7:0]    arr_data;
  logic          s1_v;
  rkind_e        s1_kind;
  logic [7:0]    s1_sig, s1_poll;

  assign rise     = !strb_q && strobe_n_i;
  assign start_wr = rise && !busy && (mode_i == CMD_WRITE) && arr_blank;
  assign start_lk = rise && !busy && ((mode_i == CMD_LOCK1) || (mode_i == CMD_LOCK2));
  assign ready_o  = !busy;

  always_ff @(posedge clk) begin
    if (rst) strb_q <= 1'b1;
    else     strb_q <= strobe_n_i;
  end

  nvm_op_timer #(.CYCLES(WRITE_CYC)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (start_wr || start_lk),
    .busy  (busy),
    .done  (done)
  );

  nvm_erase_hold #(.HOLD(ERASE_CYC)) u_erase (
    .clk      (clk),
    .rst      (rst),
    .hold_req (!busy && (mode_i == CMD_ERASE) && !strobe_n_i),
    .fire     (erase_fire)
  );

  nvm_code_array #(.AW(AW)) u_array (
    .clk       (clk),
    .rst       (rst),
    .clear     (erase_fire),
    .we        (done && !op_lock),
    .waddr     (pend_addr),
    .wdata     (pend_data),
    .raddr     (addr_i),
    .chk_addr  (addr_i),
    .rdata     (arr_data),
    .rvalid    (arr_valid),
    .chk_blank (arr_blank)
  );

  // Capture of the operation in flight.
  always_ff @(posedge clk) begin
    if (rst) begin
      op_lock   <= 1'b0;
      op_sel2   <= 1'b0;
      pend_addr <= '0;
      pend_data <= BLANK_BYTE;
    end else if (start_wr) begin
      op_lock   <= 1'b0;
      pend_addr <= addr_i;
      pend_data <= data_i;
    end else if (start_lk) begin
      op_lock <= 1'b1;
      op_sel2 <= (mode_i == CMD_LOCK2);
    end
  end

  // Protection bits: set at completion, cleared only by erase or reset.
  always_ff @(posedge clk) begin
    if (rst || erase_fire) begin
      lb1 <= 1'b0;
      lb2 <= 1'b0;
    end else if (done && op_lock) begin
      if (op_sel2) lb2 <= 1'b1;
      else         lb1 <= 1'b1;
    end
  end

  // Read stage 1: classify the request alongside the RAM read.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v    <= 1'b0;
      s1_kind <= RK_ARRAY;
      s1_sig  <= BLANK_BYTE;
      s1_poll <= BLANK_BYTE;
    end else begin
      s1_v    <= (mode_i == CMD_VERIFY) || (mode_i == CMD_SIGN);
      s1_sig  <= sig_byte(16'(addr_i), HV_VARIANT);
      s1_poll <= {~pend_data[7], pend_data[6:0]};
      if (mode_i == CMD_SIGN)  s1_kind <= RK_SIGN;
      else if (lb1 && lb2)     s1_kind <= RK_LOCKED;
      else if (busy && !op_lock) s1_kind <= RK_POLL;
      else                     s1_kind <= RK_ARRAY;
    end
  end

  // Read stage 2: registered output mux.
  always_ff @(posedge clk) begin
    if (rst) rdata_o <= BLANK_BYTE;
    else if (s1_v) begin
      case (s1_kind)
        RK_SIGN:   rdata_o <= s1_sig;
        RK_LOCKED: rdata_o <= HIDDEN_BYTE;
        RK_POLL:   rdata_o <= s1_poll;
        default:   rdata_o <= arr_valid ? arr_data : BLANK_BYTE;
      endcase
    end
  end
endmodule

// File: rtl/nvm_prog_chk.sv
module nvm_prog_chk #(
  parameter int unsigned AW         = 8,
  parameter int unsigned WRITE_CYC  = 16,
  parameter bit          HV_VARIANT = 1'b1
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] addr_i,
  input logic [2:0]    mode_i,
  input logic          strobe_n_i,
  input logic          ready_o,
  input logic [7:0]    rdata_o
);
  logic        past_rst;
  int unsigned lowcnt;

  always_ff @(posedge clk) begin
    past_rst <= rst;
    if (past_rst) begin
      a_r1_reset_state: assert (ready_o && (rdata_o == 8'hFF));
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           lowcnt <= 0;
    else if (!ready_o) lowcnt <= lowcnt + 1;
    else               lowcnt <= 0;
  end

  a_r3_busy_len: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_o) |-> (lowcnt == WRITE_CYC));

  a_r4_start_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(ready_o) |-> ($past(strobe_n_i) && !$past(strobe_n_i, 2) &&
                        (($past(mode_i) == 3'd1) || ($past(mode_i) == 3'd5) ||
                         ($past(mode_i) == 3'd6))));

  a_r7_sig_maker: assert property (@(posedge clk) disable iff (rst)
    ((mode_i == 3'd4) && (addr_i == AW'(8'h30))) |-> ##2 (rdata_o == 8'h1E));

  a_r7_sig_variant: assert property (@(posedge clk) disable iff (rst)
    ((mode_i == 3'd4) && (addr_i == AW'(8'h32))) |->
      ##2 (rdata_o == (HV_VARIANT ? 8'hFF : 8'h05)));

  a_r8_hold_rdata: assert property (@(posedge clk) disable iff (rst)
    !(($past(mode_i, 2) == 3'd2) || ($past(mode_i, 2) == 3'd4)) |-> $stable(rdata_o));
endmodule

bind nvm_prog_ctrl nvm_prog_chk #(
  .AW(AW), .WRITE_CYC(WRITE_CYC), .HV_VARIANT(HV_VARIANT)
) u_chk (
  .clk(clk), .rst(rst), .addr_i(addr_i), .mode_i(mode_i),
  .strobe_n_i(strobe_n_i), .ready_o(ready_o), .rdata_o(rdata_o)
);

// File: tb/sim_nvm_prog_ctrl.sv
`timescale 1ns/1ps
module sim_nvm_prog_ctrl;
  localparam int AW = 8;
  localparam int W  = 12;
  localparam int E  = 30;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] addr_i;
  logic [7:0]    data_i;
  logic [2:0]    mode_i;
  logic          strobe_n_i;
  logic          ready_o;
  logic [7:0]    rdata_o;

  always #2.5 clk = ~clk;

  nvm_prog_ctrl #(.AW(AW), .WRITE_CYC(W), .ERASE_CYC(E), .HV_VARIANT(1'b1)) u0 (
    .clk(clk), .rst(rst), .addr_i(addr_i), .data_i(data_i), .mode_i(mode_i),
    .strobe_n_i(strobe_n_i), .ready_o(ready_o), .rdata_o(rdata_o)
  );

  int total = 0;
  int bad   = 0;

  // ---------------- behavioural reference ----------------
  int m_mem [256];
  bit m_used [256];
  bit m_lb1, m_lb2, m_busy, m_oplock, m_opsel2, m_sprev, m_s1v;
  int m_cnt, m_pa, m_pd, m_ecnt, m_s1val, m_rdata, m_nv;
  bit m_rise, m_hold;

  function automatic int sigv(int a);
    if (a == 'h30) return 'h1E;
    if (a == 'h31) return 'h51;
    if (a == 'h32) return 'hFF;
    return 'hFF;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_used[i]) m_used[i] = 1'b0;
      m_lb1 = 0; m_lb2 = 0; m_busy = 0; m_oplock = 0; m_opsel2 = 0;
      m_sprev = 1; m_s1v = 0; m_cnt = 0; m_pa = 0; m_pd = 'hFF;
      m_ecnt = 0; m_s1val = 'hFF; m_rdata = 'hFF;
    end else begin
      if (mode_i == 3'd4)              m_nv = sigv(int'(addr_i));
      else if (m_lb1 && m_lb2)         m_nv = 0;
      else if (m_busy && !m_oplock)    m_nv = m_pd ^ 'h80;
      else if (m_used[addr_i])         m_nv = m_mem[addr_i];
      else                             m_nv = 'hFF;
      if (m_s1v) m_rdata = m_s1val;
      m_s1v   = (mode_i == 3'd2) || (mode_i == 3'd4);
      m_s1val = m_nv;
      m_rise  = !m_sprev && strobe_n_i;
      m_hold  = !m_busy && (mode_i == 3'd3) && !strobe_n_i;
      if (m_busy) begin
        if (m_cnt == 1) begin
          m_busy = 0;
          if (m_oplock) begin
            if (m_opsel2) m_lb2 = 1; else m_lb1 = 1;
          end else begin
            m_mem[m_pa] = m_pd; m_used[m_pa] = 1;
          end
        end
        m_cnt = m_cnt - 1;
      end else if (m_rise && mode_i == 3'd1 && !m_used[addr_i]) begin
        m_busy = 1; m_cnt = W; m_oplock = 0; m_pa = int'(addr_i); m_pd = int'(data_i);
      end else if (m_rise && (mode_i == 3'd5 || mode_i == 3'd6)) begin
        m_busy = 1; m_cnt = W; m_oplock = 1; m_opsel2 = (mode_i == 3'd6);
      end
      if (m_hold) begin
        if (m_ecnt == E - 1) begin
          foreach (m_used[i]) m_used[i] = 1'b0;
          m_lb1 = 0; m_lb2 = 0;
        end
        if (m_ecnt < E) m_ecnt = m_ecnt + 1;
      end else m_ecnt = 0;
      m_sprev = strobe_n_i;
    end
  end

  // Cycle-by-cycle comparison against the reference.
  always @(negedge clk) begin
    if (!rst) begin
      total++;
      if (ready_o !== !m_busy) begin
        bad++;
        $display("FAIL R3 ready_o per-cycle: got %0b exp %0b", ready_o, !m_busy);
      end
      total++;
      if (rdata_o !== m_rdata[7:0]) begin
        bad++;
        $display("FAIL R8 rdata_o per-cycle: got %02h exp %02h", rdata_o, m_rdata[7:0]);
      end
    end
  end

  // ---------------- directed checks ----------------
  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %02h exp %02h", tag, got, exp);
    end
  endtask

  task automatic rd(input int a, input logic [2:0] m, input int exp, input string tag);
    @(negedge clk); addr_i = AW'(a); mode_i = m;
    @(negedge clk); mode_i = 3'd0;
    @(negedge clk); chk(tag, int'(rdata_o), exp);
  endtask

  task automatic prog(input int a, input int d, input logic [2:0] m,
                      input bit exp_ready, input string tag);
    @(negedge clk); addr_i = AW'(a); data_i = 8'(d); mode_i = m; strobe_n_i = 1'b0;
    @(negedge clk);
    @(negedge clk); strobe_n_i = 1'b1;
    @(negedge clk); chk(tag, int'(ready_o), int'(exp_ready));
    mode_i = 3'd0;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 200 && !ready_o; i++) @(negedge clk);
    chk("R3 ready returns", int'(ready_o), 1);
  endtask

  task automatic erase_hold(input int n);
    @(negedge clk); mode_i = 3'd3; strobe_n_i = 1'b0;
    repeat (n) @(negedge clk);
    strobe_n_i = 1'b1; mode_i = 3'd0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    bad++; total++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; addr_i = '0; data_i = '0; mode_i = 3'd0; strobe_n_i = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    chk("R1 ready after reset", int'(ready_o), 1);
    chk("R1 rdata after reset", int'(rdata_o), 'hFF);

    rd(5, 3'd2, 'hFF, "R2 blank read");

    prog(5, 'h5A, 3'd1, 1'b0, "R4 write starts busy");
    rd(5, 3'd2, 'hDA, "R6 poll inverted bit7");
    rd(77, 3'd2, 'hDA, "R6 poll any address");
    wait_ready();
    rd(5, 3'd2, 'h5A, "R5 written byte");

    prog(9, 'hC3, 3'd1, 1'b0, "R3 second write busy");
    rd(9, 3'd2, 'h43, "R6 poll bit7 set");
    wait_ready();
    rd(9, 3'd2, 'hC3, "R5 second byte");

    prog(5, 'h00, 3'd1, 1'b1, "R9 rewrite rejected");
    rd(5, 3'd2, 'h5A, "R9 byte kept");

    prog(6, 'h11, 3'd1, 1'b0, "R10 first write");
    prog(7, 'h22, 3'd1, 1'b0, "R10 strobe during busy");
    erase_hold(E);
    wait_ready();
    repeat (3) @(negedge clk);
    chk("R10 no late start", int'(ready_o), 1);
    rd(7, 3'd2, 'hFF, "R10 ignored target blank");
    rd(6, 3'd2, 'h11, "R10 erase during busy ignored");

    rd('h30, 3'd4, 'h1E, "R7 signature 30");
    rd('h31, 3'd4, 'h51, "R7 signature 31");
    rd('h32, 3'd4, 'hFF, "R7 signature 32");
    rd('h33, 3'd4, 'hFF, "R7 signature other");

    prog(0, 0, 3'd5, 1'b0, "R11 lock1 busy");
    wait_ready();
    rd(5, 3'd2, 'h5A, "R11 one bit no effect");
    prog(0, 0, 3'd6, 1'b0, "R11 lock2 busy");
    wait_ready();
    rd(5, 3'd2, 'h00, "R11 verify hidden");
    rd('h31, 3'd4, 'h51, "R11 signature unaffected");

    erase_hold(E - 5);
    rd(5, 3'd2, 'h00, "R12 short hold no erase");
    erase_hold(E);
    rd(5, 3'd2, 'hFF, "R12 erased location");
    rd(9, 3'd2, 'hFF, "R2 erased reads blank");

    prog(5, 'h33, 3'd1, 1'b0, "R9 write after erase");
    wait_ready();
    rd(5, 3'd2, 'h33, "R9 new byte");

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule